// File: doc/BRIEF.md
# SDRAM Read-and-Close Command Sequencer

This block drives the command and address pins of one SDRAM bank for a single kind of transaction: open a row, read a burst from it, then close the row. A request names the bank, row and starting column, selects either the programmed fixed burst or full-page mode, gives the number of beats actually wanted, and picks a CAS latency of 2 or 3. The sequencer emits ACTIVE, waits the row-to-column delay, emits READ, fills the gaps with NOP, and closes the row with a PRECHARGE. After the PRECHARGE it refuses new work until the row-precharge time has run out.

The PRECHARGE is placed CAS-latency-minus-one cycles ahead of the cycle in which the last wanted beat is on the data bus. Part of the precharge time is therefore hidden behind the final beats. A fixed burst can be cut short, and a full-page burst, which never ends by itself, is ended at the requested length. A data-valid strobe marks each wanted beat, and the data mask stays low for the whole read.

Top module: `sdram_rdpre_seq`

## Requirements
- R1: After reset, `req_ready` is 1, `sd_cmd` is NOP, `rd_valid` is 0 and `sd_dqm` is 1.
- R2: `sd_cmd` is coded {cs_n, ras_n, cas_n, we_n}: NOP 4'b0111, ACTIVE 4'b0011, READ 4'b0101, PRECHARGE 4'b0010. ACTIVE carries the row on `sd_addr` and the bank on `sd_bank`. READ carries the column in the low `COL_W` bits of `sd_addr` with bit `AP_BIT` at 0, so auto-precharge is never used. PRECHARGE carries the bank with bit `AP_BIT` at 0. Each transaction issues exactly one of each, and every other cycle is NOP.
- R3: READ comes exactly `T_RCD` cycles after ACTIVE.
- R4: `rd_valid` first rises exactly CL cycles after the READ cycle. CL is 3 when `req_cl3` was 1 at acceptance and 2 otherwise. The strobe then stays high for contiguous cycles.
- R5: PRECHARGE is issued exactly CL-1 cycles before the last cycle in which `rd_valid` is high. For N beats this is N cycles after READ.
- R6: In fixed mode (`req_full_page`=0), N is `req_beats` when it lies in 1..`BURST_LEN`. Otherwise N is `BURST_LEN`, which gives the full uncut burst.
- R7: In full-page mode, N is `req_beats` when it lies in 1..2^`COL_W`. A value of 0 gives the whole page of 2^`COL_W` beats.
- R8: After a PRECHARGE, no command other than NOP appears for `T_RP` cycles. With a request waiting, the next ACTIVE comes exactly `T_RP` cycles after the PRECHARGE.
- R9: `req_ready` is high only while the sequencer is idle. A request is taken when `req_valid` and `req_ready` are both 1, and ACTIVE is on the bus in the next cycle.
- R10: `sd_dqm` is 0 in every cycle in which `rd_valid` is 1.
- R11: With one wanted beat and CL 3, PRECHARGE is issued in the cycle right after READ, while `rd_valid` still marks only one beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_bank | input | BANK_W | Target bank |
| req_row | input | ROW_W | Row to open |
| req_col | input | COL_W | Starting column |
| req_full_page | input | 1 | 1 selects full-page mode, 0 selects fixed burst |
| req_beats | input | COL_W+1 | Wanted beats; 0 means the whole burst or page |
| req_cl3 | input | 1 | 1 selects CAS latency 3, 0 selects 2 |
| sd_cmd | output | 4 | Command {cs_n, ras_n, cas_n, we_n} |
| sd_bank | output | BANK_W | Bank address |
| sd_addr | output | ADDR_W | Row or column address |
| sd_dqm | output | 1 | Data mask, low while a read is in flight |
| rd_valid | output | 1 | High in each cycle a wanted beat is on DQ |

## Verification
The bench builds the block with `COL_W`=5, `T_RCD`=3 and `T_RP`=4, and keeps `BURST_LEN`=4. The 32-beat page allows a whole-page read and a page read cut short to be run in a few hundred cycles. A row-to-column delay of 3 gives two NOP cycles between ACTIVE and READ. A precharge time of 4 is longer than either CAS latency, so the cycle in which the sequencer becomes ready again differs from the cycle of the last data beat, and the back-to-back gap can be measured apart from the data tail.

// File: rtl/sdram_rdpre_pkg.sv
// Package: shared command codes and sequencer states.
// Assumes the command is coded {cs_n, ras_n, cas_n, we_n}.
package sdram_rdpre_pkg;

    typedef enum logic [3:0] {
        CMD_NOP = 4'b0111,
        CMD_ACT = 4'b0011,
        CMD_RD  = 4'b0101,
        CMD_PRE = 4'b0010
    } sd_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACTIVATE,
        ST_RCD_WAIT,
        ST_READ_ISSUE,
        ST_BURST,
        ST_PRECHARGE,
        ST_RP_WAIT
    } seq_state_e;

endpackage

// File: rtl/sdram_rdpre_fsm.sv
// Module: command FSM. It takes a request, opens the row, issues READ after
// T_RCD cycles, and issues PRECHARGE N cycles after READ. N is the wanted
// beat count, so the PRECHARGE lands CL-1 cycles before the last beat for
// either CL. It then holds off new work for T_RP cycles.
// Assumes COL_W <= AP_BIT < ADDR_W, ROW_W <= ADDR_W, T_RCD >= 1, T_RP >= 1.
module sdram_rdpre_fsm
    import sdram_rdpre_pkg::*;
#(
    parameter int BANK_W    = 2,
    parameter int ROW_W     = 12,
    parameter int COL_W     = 8,
    parameter int ADDR_W    = 12,
    parameter int AP_BIT    = 10,
    parameter int BURST_LEN = 4,
    parameter int T_RCD     = 2,
    parameter int T_RP      = 3,
    localparam int LEN_W    = COL_W + 1,
    localparam int RP_W     = $clog2(T_RP + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic              req_full_page,
    input  logic [LEN_W-1:0]  req_beats,
    input  logic              req_cl3,
    output logic [3:0]        cmd_o,
    output logic [BANK_W-1:0] bank_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              beat_o,
    output logic              busy_o,
    output logic              cl3_o
);

    localparam logic [LEN_W-1:0] PAGE_LEN = LEN_W'(1 << COL_W);
    localparam logic [LEN_W-1:0] FIX_LEN  = LEN_W'(BURST_LEN);
    localparam logic [LEN_W-1:0] RCD_LOAD = LEN_W'(T_RCD - 1);
    localparam logic [RP_W-1:0]  RP_LOAD  = RP_W'(T_RP - 1);

    seq_state_e        state;
    logic [LEN_W-1:0]  cnt;
    logic [LEN_W-1:0]  beats_m1;
    logic [LEN_W-1:0]  eff_beats;
    logic [RP_W-1:0]   rp_cnt;
    logic [BANK_W-1:0] bank_q;
    logic [ROW_W-1:0]  row_q;
    logic [COL_W-1:0]  col_q;
    logic              cl3_q;
    sd_cmd_e           cmd;

    // Work out how many beats the request resolves to, after clamping.
    always_comb begin
        if (req_full_page) begin
            eff_beats = (req_beats == '0 || req_beats > PAGE_LEN) ? PAGE_LEN : req_beats;
        end else begin
            eff_beats = (req_beats == '0 || req_beats > FIX_LEN) ? FIX_LEN : req_beats;
        end
    end

    // Step through the states and keep the shared delay counter and the tRP counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            beats_m1 <= '0;
            rp_cnt   <= '0;
            bank_q   <= '0;
            row_q    <= '0;
            col_q    <= '0;
            cl3_q    <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req_valid && rp_cnt == '0) begin
                        state    <= ST_ACTIVATE;
                        cnt      <= RCD_LOAD;
                        beats_m1 <= eff_beats - LEN_W'(1);
                        bank_q   <= req_bank;
                        row_q    <= req_row;
                        col_q    <= req_col;
                        cl3_q    <= req_cl3;
                    end
                end
                ST_ACTIVATE, ST_RCD_WAIT: begin
                    if (cnt == '0) begin
                        state <= ST_READ_ISSUE;
                        cnt   <= beats_m1;
                    end else begin
                        state <= ST_RCD_WAIT;
                        cnt   <= cnt - LEN_W'(1);
                    end
                end
                ST_READ_ISSUE, ST_BURST: begin
                    if (cnt == '0) begin
                        state  <= ST_PRECHARGE;
                        rp_cnt <= RP_LOAD;
                    end else begin
                        state <= ST_BURST;
                        cnt   <= cnt - LEN_W'(1);
                    end
                end
                ST_PRECHARGE, ST_RP_WAIT: begin
                    if (rp_cnt != '0) begin
                        rp_cnt <= rp_cnt - RP_W'(1);
                    end
                    state <= (rp_cnt <= RP_W'(1)) ? ST_IDLE : ST_RP_WAIT;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Decode the current state into the command and address on the bus.
    always_comb begin
        cmd    = CMD_NOP;
        addr_o = '0;
        case (state)
            ST_ACTIVATE: begin
                cmd    = CMD_ACT;
                addr_o = ADDR_W'(row_q);
            end
            ST_READ_ISSUE: begin
                cmd            = CMD_RD;
                addr_o         = ADDR_W'(col_q);
                addr_o[AP_BIT] = 1'b0;
            end
            ST_PRECHARGE: begin
                cmd            = CMD_PRE;
                addr_o[AP_BIT] = 1'b0;
            end
            default: cmd = CMD_NOP;
        endcase
    end

    // Drive the outputs seen by the data-valid pipe and the top level.
    assign cmd_o     = cmd;
    assign bank_o    = bank_q;
    assign req_ready = (state == ST_IDLE);
    assign beat_o    = (state == ST_READ_ISSUE) || (state == ST_BURST);
    assign busy_o    = (state != ST_IDLE);
    assign cl3_o     = cl3_q;

endmodule

// File: rtl/sdram_rdpre_dv.sv
// Module: data-valid delay pipe. A beat marker from the READ/BURST cycles
// enters at a depth chosen by the CAS latency and comes out CL cycles later.
// Beats already in flight keep their timing when the latency changes.
// Assumes a CAS latency of 2 or 3.
module sdram_rdpre_dv #(
    parameter int MAX_CL = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic beat_i,
    input  logic cl3_i,
    output logic valid_o,
    output logic busy_o
);

    logic [MAX_CL-1:0] sr;
    logic [MAX_CL-1:0] sr_next;

    // Shift toward bit 0 and put a new marker in at depth CL-1.
    always_comb begin
        sr_next = sr >> 1;
        if (beat_i) begin
            sr_next[cl3_i ? 2 : 1] = 1'b1;
        end
    end

    // Hold the pipe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr <= '0;
        end else begin
            sr <= sr_next;
        end
    end

    assign valid_o = sr[0];
    assign busy_o  = |sr;

endmodule

// File: rtl/sdram_rdpre_seq.sv
// Module: top of the read-and-close sequencer. It joins the command FSM and
// the data-valid pipe and drives the data mask low while a read is in flight.
// Assumes one bank per instance and CAS latency 2 or 3 per request.
module sdram_rdpre_seq #(
    parameter int BANK_W    = 2,
    parameter int ROW_W     = 12,
    parameter int COL_W     = 8,
    parameter int ADDR_W    = 12,
    parameter int AP_BIT    = 10,
    parameter int BURST_LEN = 4,
    parameter int T_RCD     = 2,
    parameter int T_RP      = 3,
    localparam int LEN_W    = COL_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic              req_full_page,
    input  logic [LEN_W-1:0]  req_beats,
    input  logic              req_cl3,
    output logic [3:0]        sd_cmd,
    output logic [BANK_W-1:0] sd_bank,
    output logic [ADDR_W-1:0] sd_addr,
    output logic              sd_dqm,
    output logic              rd_valid
);

    logic beat;
    logic fsm_busy;
    logic dv_busy;
    logic cl3_q;

    sdram_rdpre_fsm #(
        .BANK_W   (BANK_W),
        .ROW_W    (ROW_W),
        .COL_W    (COL_W),
        .ADDR_W   (ADDR_W),
        .AP_BIT   (AP_BIT),
        .BURST_LEN(BURST_LEN),
        .T_RCD    (T_RCD),
        .T_RP     (T_RP)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_bank     (req_bank),
        .req_row      (req_row),
        .req_col      (req_col),
        .req_full_page(req_full_page),
        .req_beats    (req_beats),
        .req_cl3      (req_cl3),
        .cmd_o        (sd_cmd),
        .bank_o       (sd_bank),
        .addr_o       (sd_addr),
        .beat_o       (beat),
        .busy_o       (fsm_busy),
        .cl3_o        (cl3_q)
    );

    sdram_rdpre_dv #(
        .MAX_CL(3)
    ) u_dv (
        .clk    (clk),
        .rst_n  (rst_n),
        .beat_i (beat),
        .cl3_i  (cl3_q),
        .valid_o(rd_valid),
        .busy_o (dv_busy)
    );

    // Hold the mask low from ACTIVE until the last beat has left the pipe.
    assign sd_dqm = !(fsm_busy || dv_busy);

endmodule

// File: rtl/sdram_rdpre_chk.sv
// Module: protocol checker bound to the sequencer. It counts cycles since
// the last ACTIVE, READ and PRECHARGE and relates them to the bus.
// Assumes the command coding from the package.
module sdram_rdpre_chk
    import sdram_rdpre_pkg::*;
#(
    parameter int T_RCD = 2,
    parameter int T_RP  = 3
) (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic [3:0] sd_cmd,
    input logic       ap_bit,
    input logic       sd_dqm,
    input logic       rd_valid,
    input logic       cl3_q
);

    logic [7:0] since_act;
    logic [7:0] since_rd;
    logic [7:0] since_pre;

    // Saturating cycle counters since each command was seen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_act <= 8'hFF;
            since_rd  <= 8'hFF;
            since_pre <= 8'hFF;
        end else begin
            since_act <= (sd_cmd == CMD_ACT) ? 8'd1 : (since_act == 8'hFF ? since_act : since_act + 8'd1);
            since_rd  <= (sd_cmd == CMD_RD)  ? 8'd1 : (since_rd  == 8'hFF ? since_rd  : since_rd  + 8'd1);
            since_pre <= (sd_cmd == CMD_PRE) ? 8'd1 : (since_pre == 8'hFF ? since_pre : since_pre + 8'd1);
        end
    end

    AST_READ_NO_AUTOPRE: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_cmd == CMD_RD) |-> !ap_bit); // R2
    AST_RCD_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_cmd == CMD_RD) |-> (since_act == 8'(T_RCD))); // R3
    AST_FIRST_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_valid) |-> (since_rd == (cl3_q ? 8'd3 : 8'd2))); // R4
    AST_PRE_BEFORE_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_valid) |-> (since_pre == (cl3_q ? 8'd3 : 8'd2))); // R5
    AST_RP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_cmd != CMD_NOP) |-> (since_pre >= 8'(T_RP))); // R8
    AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (sd_cmd == CMD_NOP)); // R9
    AST_ACCEPT_ACT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (sd_cmd == CMD_ACT)); // R9
    AST_DQM_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !sd_dqm); // R10

endmodule

bind sdram_rdpre_seq sdram_rdpre_chk #(
    .T_RCD(T_RCD),
    .T_RP (T_RP)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .sd_cmd   (sd_cmd),
    .ap_bit   (sd_addr[AP_BIT]),
    .sd_dqm   (sd_dqm),
    .rd_valid (rd_valid),
    .cl3_q    (cl3_q)
);

// File: tb/sdram_rdpre_seq_bench.sv
// Directed bench: one task per scenario, each checking its own results.
module sdram_rdpre_seq_bench;

    localparam int BANK_W    = 2;
    localparam int ROW_W     = 12;
    localparam int COL_W     = 5;
    localparam int ADDR_W    = 12;
    localparam int AP_BIT    = 10;
    localparam int BURST_LEN = 4;
    localparam int T_RCD     = 3;
    localparam int T_RP      = 4;
    localparam int LEN_W     = COL_W + 1;
    localparam int PAGE      = 1 << COL_W;

    localparam logic [3:0] C_NOP = 4'b0111;
    localparam logic [3:0] C_ACT = 4'b0011;
    localparam logic [3:0] C_RD  = 4'b0101;
    localparam logic [3:0] C_PRE = 4'b0010;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [BANK_W-1:0] req_bank = '0;
    logic [ROW_W-1:0]  req_row = '0;
    logic [COL_W-1:0]  req_col = '0;
    logic              req_full_page = 1'b0;
    logic [LEN_W-1:0]  req_beats = '0;
    logic              req_cl3 = 1'b0;
    logic [3:0]        sd_cmd;
    logic [BANK_W-1:0] sd_bank;
    logic [ADDR_W-1:0] sd_addr;
    logic              sd_dqm;
    logic              rd_valid;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    sdram_rdpre_seq #(
        .BANK_W   (BANK_W),
        .ROW_W    (ROW_W),
        .COL_W    (COL_W),
        .ADDR_W   (ADDR_W),
        .AP_BIT   (AP_BIT),
        .BURST_LEN(BURST_LEN),
        .T_RCD    (T_RCD),
        .T_RP     (T_RP)
    ) u_sdram_rdpre_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_bank     (req_bank),
        .req_row      (req_row),
        .req_col      (req_col),
        .req_full_page(req_full_page),
        .req_beats    (req_beats),
        .req_cl3      (req_cl3),
        .sd_cmd       (sd_cmd),
        .sd_bank      (sd_bank),
        .sd_addr      (sd_addr),
        .sd_dqm       (sd_dqm),
        .rd_valid     (rd_valid)
    );

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    // Issue one read and check its whole timeline. Entered and left at a negedge.
    task automatic run_read(input bit full, input int beats, input bit cl3, input int exp_n,
                            input logic [BANK_W-1:0] bank, input logic [ROW_W-1:0] row,
                            input logic [COL_W-1:0] col, input string tag);
        int cl = cl3 ? 3 : 2;
        int t_rd = -1;
        int t_pre = -1;
        int dv_f = -1;
        int dv_l = -1;
        int dv_n = 0;
        int stray = 0;
        int dqm_bad = 0;
        int rdy = -1;
        int addr_bad = 0;
        while (!req_ready) @(negedge clk);
        req_full_page = full;
        req_beats     = LEN_W'(beats);
        req_cl3       = cl3;
        req_bank      = bank;
        req_row       = row;
        req_col       = col;
        req_valid     = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(sd_cmd == C_ACT, {tag, " R9 ACTIVE after accept"}, int'(sd_cmd), int'(C_ACT));
        chk(req_ready == 1'b0, {tag, " R9 ready low when busy"}, int'(req_ready), 0);
        chk(sd_addr == ADDR_W'(row) && sd_bank == bank, {tag, " R2 ACTIVE row/bank"},
            int'(sd_addr), int'(row));
        for (int k = 1; k <= T_RCD + exp_n + T_RP + 2; k++) begin
            @(negedge clk);
            if (sd_cmd == C_RD) begin
                if (t_rd >= 0) stray++;
                t_rd = k;
                if (sd_addr[COL_W-1:0] != col || sd_addr[AP_BIT] || sd_bank != bank) addr_bad++;
            end else if (sd_cmd == C_PRE) begin
                if (t_pre >= 0) stray++;
                t_pre = k;
                if (sd_addr[AP_BIT] || sd_bank != bank) addr_bad++;
            end else if (sd_cmd != C_NOP) begin
                stray++;
            end
            if (rd_valid) begin
                if (dv_f < 0) dv_f = k;
                dv_l = k;
                dv_n++;
                if (sd_dqm) dqm_bad++;
            end
            if (req_ready && rdy < 0) rdy = k;
        end
        chk(t_rd == T_RCD, {tag, " R3 READ after ACTIVE"}, t_rd, T_RCD);
        chk(dv_f == T_RCD + cl, {tag, " R4 first beat"}, dv_f, T_RCD + cl);
        chk(dv_l - dv_f + 1 == dv_n, {tag, " R4 contiguous beats"}, dv_n, dv_l - dv_f + 1);
        chk(dv_n == exp_n, {tag, " R6 R7 beat count"}, dv_n, exp_n);
        chk(t_pre == T_RCD + exp_n, {tag, " R5 PRECHARGE cycle"}, t_pre, T_RCD + exp_n);
        chk(dv_l - t_pre == cl - 1, {tag, " R5 PRECHARGE lead"}, dv_l - t_pre, cl - 1);
        chk(stray == 0 && addr_bad == 0, {tag, " R2 command/address"}, stray + addr_bad, 0);
        chk(dqm_bad == 0, {tag, " R10 dqm low on beats"}, dqm_bad, 0);
        chk(rdy == t_pre + T_RP - 1, {tag, " R8 ready after tRP"}, rdy, t_pre + T_RP - 1);
    endtask

    task automatic tc_reset();
        chk(req_ready == 1'b1, "R1 ready", int'(req_ready), 1);
        chk(sd_cmd == C_NOP, "R1 cmd", int'(sd_cmd), int'(C_NOP));
        chk(rd_valid == 1'b0, "R1 rd_valid", int'(rd_valid), 0);
        chk(sd_dqm == 1'b1, "R1 dqm", int'(sd_dqm), 1);
    endtask

    task automatic tc_fixed_whole_cl2();
        run_read(1'b0, 0, 1'b0, BURST_LEN, 2'd1, 12'h123, 5'd4, "fixed0 cl2 R6");
    endtask

    task automatic tc_fixed_whole_cl3();
        run_read(1'b0, 4, 1'b1, BURST_LEN, 2'd2, 12'h0F0, 5'd8, "fixed4 cl3 R6");
    endtask

    task automatic tc_fixed_cut();
        run_read(1'b0, 2, 1'b1, 2, 2'd3, 12'h7AA, 5'd17, "fixed2 cl3 R5");
        run_read(1'b0, 3, 1'b0, 3, 2'd0, 12'h001, 5'd30, "fixed3 cl2 R5");
    endtask

    task automatic tc_single_beat();
        run_read(1'b0, 1, 1'b1, 1, 2'd1, 12'h555, 5'd1, "single cl3 R11");
        run_read(1'b0, 1, 1'b0, 1, 2'd2, 12'h2AA, 5'd2, "single cl2 R11");
    endtask

    task automatic tc_fixed_clamp();
        run_read(1'b0, 7, 1'b0, BURST_LEN, 2'd0, 12'h010, 5'd0, "fixed7 R6 clamp");
    endtask

    task automatic tc_full_page();
        run_read(1'b1, 10, 1'b0, 10, 2'd1, 12'h333, 5'd5, "page10 cl2 R7");
        run_read(1'b1, 0, 1'b1, PAGE, 2'd3, 12'hABC, 5'd0, "page0 cl3 R7");
    endtask

    // Hold a request waiting so two reads run back to back; measure the PRECHARGE to ACTIVE gap.
    task automatic tc_back_to_back();
        int k = 0;
        int t_pre = -1;
        int t_act2 = -1;
        int n_act = 0;
        int busy_cmd = 0;
        while (!req_ready) @(negedge clk);
        req_full_page = 1'b0;
        req_beats     = LEN_W'(2);
        req_cl3       = 1'b0;
        req_bank      = 2'd1;
        req_row       = 12'h444;
        req_col       = 5'd3;
        req_valid     = 1'b1;
        while (k < 80 && t_act2 < 0) begin
            @(negedge clk);
            k++;
            if (sd_cmd == C_ACT) begin
                n_act++;
                if (n_act == 2) begin
                    t_act2 = k;
                    req_valid = 1'b0;
                end
            end else if (sd_cmd == C_PRE) begin
                t_pre = k;
            end else if (sd_cmd != C_NOP && t_pre >= 0) begin
                busy_cmd++;
            end
        end
        chk(t_act2 - t_pre == T_RP, "R8 PRECHARGE to ACTIVE gap", t_act2 - t_pre, T_RP);
        chk(busy_cmd == 0, "R8 quiet during tRP", busy_cmd, 0);
        repeat (20) @(negedge clk);
        chk(req_ready == 1'b1, "R9 ready back after drain", int'(req_ready), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        tc_reset();
        tc_fixed_whole_cl2();
        tc_fixed_whole_cl3();
        tc_fixed_cut();
        tc_single_beat();
        tc_fixed_clamp();
        tc_full_page();
        tc_back_to_back();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule